// File: doc/BRIEF.md
# Pipelined Synchronous Memory Front End

This block is a clocked front end for a small on-chip memory built from 9-bit byte lanes. At each rising clock edge it decides whether a new access starts. Two active-low address strobes can start one. The controller strobe always starts an access. The processor strobe starts one only while chip enable is asserted. The address, the write intent and the write data are captured in a stage register. The access is then carried out against the array on the following edge, and read data comes back through a single output register.

Chip selection combines one active-low enable with an active-high and an active-low select. An access started while the chip is not selected deselects the block: the data bus is released one edge later. An asynchronous active-low output enable, and any active write input, gate the bus driver directly. A sleep input stops every register in the block while it is high, so the array contents and the pipeline state are both kept. Burst address sequencing and byte-write decode are handled outside. This block receives a ready-made per-lane write vector and a global write.

Top module: `pipe_sram_front`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending access is cleared. After that edge `data_drive` is low and `data_out` is all zero.
- R2: An access starts at an edge when `strobe_ctl_n` is low, whatever `chip_en_n` is, or when `strobe_cpu_n` is low and `chip_en_n` is low. `strobe_cpu_n` low with `chip_en_n` high is ignored, and the previous access continues unchanged.
- R3: The chip counts as selected at a starting edge only when `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. An access started while not selected writes nothing, and `data_drive` is low after the next edge (single-cycle deselect).
- R4: For a read started at edge k, `data_out` holds the stored word after edge k+1 and `data_drive` is high then, given that `out_en_n` is low and no write input is active. After edge k itself the outputs still show the previous access.
- R5: A write starts when `wr_all_n` is low or any `lane_wr` bit is high at the starting edge, and `data_in` is sampled at that edge. `wr_all_n` low writes every lane. Otherwise lane i is written where `lane_wr[i]`=1. Lane i is data bits [9i+8:9i]. The array is updated at the next edge, and unwritten lanes keep their contents.
- R6: A write access never drives the bus. An edge with no new access that follows a write turns the pending access into a read of the same address, so the written word is driven one edge later.
- R7: An edge with no new access keeps the registered address and selection, and the same location is read again at each such edge.
- R8: `out_en_n` high forces `data_drive` low at once, without waiting for a clock edge. Low, it allows drive only after a selected read.
- R9: While `wr_all_n` is low or any `lane_wr` bit is high, `data_drive` is low in that same cycle, even when no strobe is active. Write inputs without a strobe write nothing.
- R10: While `sleep` is high at an edge, no register changes at that edge, and strobes and writes presented then are lost. Operation resumes at the first edge where `sleep` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | High stops all registers and keeps contents |
| addr | input | AW (8) | Word address, captured when an access starts |
| strobe_ctl_n | input | 1 | Active-low controller strobe, not qualified by chip enable |
| strobe_cpu_n | input | 1 | Active-low processor strobe, qualified by chip enable |
| chip_en_n | input | 1 | Active-low chip enable |
| sel_hi | input | 1 | Active-high select |
| sel_lo_n | input | 1 | Active-low select |
| wr_all_n | input | 1 | Active-low global write of all lanes |
| lane_wr | input | LANES (4) | Active-high per-lane write, already decoded |
| data_in | input | LANES*9 (36) | Write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| data_out | output | LANES*9 (36) | Registered read data |
| data_drive | output | 1 | High when the data pads should be driven; low means high impedance |

## Verification
The collision of interest is `sleep` at the very edge where a strobe starts a new read or a write. A read is left established, and then a write to the same address and a read of another address are offered while `sleep` is high. The bench requires the earlier word to stay on the bus through the sleep. After wake-up, idle edges must still return the old contents of the address that was to be written. A second overlap is write inputs that are asserted without a strobe during a driven read. That cycle must show the bus released, and the next clean cycle must show the same word again.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
// Shared types for the pipelined memory front end.
package sfe_pkg;
    // Kind of access held in the stage register.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DESEL = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/sfe_decode.sv
`timescale 1ns/1ps
// Combinational decode of strobes, selects and write inputs.
// Assumes: the lane write vector comes already decoded from an outside block.
module sfe_decode
    import sfe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strobe_ctl_n,
    input  logic             strobe_cpu_n,
    input  logic             chip_en_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             wr_all_n,
    input  logic [LANES-1:0] lane_wr,
    output logic             load,
    output logic             wr_any,
    output logic [LANES-1:0] wr_mask,
    output acc_kind_t        new_kind
);
    logic chip_sel;

    // Work out selection, access start, write intent and the kind of a new access.
    always_comb begin
        chip_sel = !chip_en_n && sel_hi && !sel_lo_n;
        load     = !strobe_ctl_n || (!strobe_cpu_n && !chip_en_n);
        wr_any   = !wr_all_n || (|lane_wr);
        wr_mask  = wr_all_n ? lane_wr : {LANES{1'b1}};
        if (!chip_sel) begin
            new_kind = ACC_DESEL;
        end else if (wr_any) begin
            new_kind = ACC_WRITE;
        end else begin
            new_kind = ACC_READ;
        end
    end
endmodule

// File: rtl/sfe_stage.sv
`timescale 1ns/1ps
// Stage register: holds address, kind, lane mask and write data of the access.
// Assumes: run is low while sleeping; no new access turns a write into a read.
module sfe_stage
    import sfe_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int DW    = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  acc_kind_t        new_kind,
    input  logic [AW-1:0]    addr_in,
    input  logic [LANES-1:0] mask_in,
    input  logic [DW-1:0]    wdata_in,
    output acc_kind_t        st_kind,
    output logic [AW-1:0]    st_addr,
    output logic [LANES-1:0] st_mask,
    output logic [DW-1:0]    st_wdata
);
    // Track the kind of the pending access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_kind <= ACC_IDLE;
        end else if (run) begin
            if (load) begin
                st_kind <= new_kind;
            end else if (st_kind == ACC_WRITE) begin
                st_kind <= ACC_READ;
            end
        end
    end

    // Capture address, lane mask and write data when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_addr  <= '0;
            st_mask  <= '0;
            st_wdata <= '0;
        end else if (run && load) begin
            st_addr  <= addr_in;
            st_mask  <= mask_in;
            st_wdata <= wdata_in;
        end
    end
endmodule

// File: rtl/sfe_array.sv
`timescale 1ns/1ps
// Lane-sliced storage with a registered read port and read-valid flag.
// Assumes: the stage holds one access at a time; array contents are not reset.
module sfe_array
    import sfe_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  acc_kind_t               kind,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] lane_q;

        // Write this lane when the pending write enables it.
        always_ff @(posedge clk) begin
            if (run && kind == ACC_WRITE && mask[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Register this lane's read data for a pending read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (run && kind == ACC_READ) begin
                lane_q <= cells[addr];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_q;
    end

    // Flag that the output register holds a selected read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else if (run) begin
            rd_valid <= (kind == ACC_READ);
        end
    end
endmodule

// File: rtl/sfe_drive.sv
`timescale 1ns/1ps
// Bus driver control: combines the output enable, write inputs and read flag.
// Assumes: out_en_n and the write inputs act without a clock.
module sfe_drive (
    input  logic out_en_n,
    input  logic rd_valid,
    input  logic wr_any,
    output logic data_drive
);
    // Drive the pads only for a selected read with no write input active.
    always_comb begin
        data_drive = !out_en_n && rd_valid && !wr_any;
    end
endmodule

// File: rtl/pipe_sram_front.sv
`timescale 1ns/1ps
// Pipelined synchronous memory front end: strobe and select decode, stage
// register, lane array with registered read, asynchronous driver control.
// Assumes: sleep is treated as a clock enable for every register.
module pipe_sram_front
    import sfe_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic             strobe_ctl_n,
    input  logic             strobe_cpu_n,
    input  logic             chip_en_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             wr_all_n,
    input  logic [LANES-1:0] lane_wr,
    input  logic [DW-1:0]    data_in,
    input  logic             out_en_n,
    output logic [DW-1:0]    data_out,
    output logic             data_drive
);
    logic             run;
    logic             load;
    logic             wr_any;
    logic [LANES-1:0] wr_mask;
    acc_kind_t        new_kind;
    acc_kind_t        st_kind;
    logic [AW-1:0]    st_addr;
    logic [LANES-1:0] st_mask;
    logic [DW-1:0]    st_wdata;
    logic             rd_valid;

    assign run = !sleep;

    sfe_decode #(.LANES(LANES)) u_decode (
        .strobe_ctl_n (strobe_ctl_n),
        .strobe_cpu_n (strobe_cpu_n),
        .chip_en_n    (chip_en_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .wr_all_n     (wr_all_n),
        .lane_wr      (lane_wr),
        .load         (load),
        .wr_any       (wr_any),
        .wr_mask      (wr_mask),
        .new_kind     (new_kind)
    );

    sfe_stage #(.AW(AW), .LANES(LANES), .DW(DW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (load),
        .new_kind (new_kind),
        .addr_in  (addr),
        .mask_in  (wr_mask),
        .wdata_in (data_in),
        .st_kind  (st_kind),
        .st_addr  (st_addr),
        .st_mask  (st_mask),
        .st_wdata (st_wdata)
    );

    sfe_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .kind     (st_kind),
        .addr     (st_addr),
        .mask     (st_mask),
        .wdata    (st_wdata),
        .rd_data  (data_out),
        .rd_valid (rd_valid)
    );

    sfe_drive u_drive (
        .out_en_n   (out_en_n),
        .rd_valid   (rd_valid),
        .wr_any     (wr_any),
        .data_drive (data_drive)
    );
endmodule

// File: rtl/sfe_checker.sv
`timescale 1ns/1ps
// Port-level properties of the memory front end, bound to the top module.
module sfe_checker #(
    parameter int LANES = 4,
    parameter int DW    = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             strobe_ctl_n,
    input logic             strobe_cpu_n,
    input logic             chip_en_n,
    input logic             sel_hi,
    input logic             sel_lo_n,
    input logic             wr_all_n,
    input logic [LANES-1:0] lane_wr,
    input logic             out_en_n,
    input logic [DW-1:0]    data_out,
    input logic             data_drive
);
    logic start_now;
    logic sel_now;
    logic wr_now;
    logic rd_start;
    logic ds_start;

    assign start_now = !strobe_ctl_n || (!strobe_cpu_n && !chip_en_n);
    assign sel_now   = !chip_en_n && sel_hi && !sel_lo_n;
    assign wr_now    = !wr_all_n || (|lane_wr);
    assign rd_start  = !sleep && start_now && sel_now && !wr_now;
    assign ds_start  = !sleep && start_now && !sel_now;

    // R8: output enable high keeps the pads released
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !data_drive);

    // R9: any write input releases the pads in that cycle
    p_write_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |-> !data_drive);

    // R10: a sleeping edge leaves the read register untouched
    p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(data_out));

    // R4: a selected read is driven after the following awake edge
    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_start && rst_n) && !sleep) |=> (out_en_n || wr_now || data_drive));

    // R3: an unselected start releases the pads one edge later
    p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ds_start && rst_n) && !sleep) |=> !data_drive);
endmodule

bind pipe_sram_front sfe_checker #(.LANES(LANES), .DW(DW)) u_sfe_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .strobe_ctl_n (strobe_ctl_n),
    .strobe_cpu_n (strobe_cpu_n),
    .chip_en_n    (chip_en_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .wr_all_n     (wr_all_n),
    .lane_wr      (lane_wr),
    .out_en_n     (out_en_n),
    .data_out     (data_out),
    .data_drive   (data_drive)
);

// File: tb/pipe_sram_front_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver task steps a requirement model and queues the
// expected outputs; the monitor pops them after each rising edge and compares.
module pipe_sram_front_test;
    localparam int AW = 8, LANES = 4, LANE_W = 9, DW = LANES * LANE_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             sleep = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             strobe_ctl_n = 1'b1, strobe_cpu_n = 1'b1, chip_en_n = 1'b1;
    logic             sel_hi = 1'b0, sel_lo_n = 1'b1, wr_all_n = 1'b1;
    logic [LANES-1:0] lane_wr = '0;
    logic [DW-1:0]    data_in = '0;
    logic             out_en_n = 1'b0;
    logic [DW-1:0]    data_out;
    logic             data_drive;

    pipe_sram_front #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr),
        .strobe_ctl_n(strobe_ctl_n), .strobe_cpu_n(strobe_cpu_n),
        .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .wr_all_n(wr_all_n), .lane_wr(lane_wr), .data_in(data_in),
        .out_en_n(out_en_n), .data_out(data_out), .data_drive(data_drive)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Expected-item queues.
    bit          q_drv[$];
    logic [DW-1:0] q_dat[$];
    string       q_tag[$];

    // Model state: 0 idle, 1 read, 2 write, 3 deselect.
    logic [DW-1:0]    m_mem [1 << AW];
    int               m_kind = 0;
    logic [AW-1:0]    m_addr = '0;
    logic [LANES-1:0] m_mask = '0;
    logic [DW-1:0]    m_wdata = '0;
    bit               m_rsel = 1'b0;
    logic [DW-1:0]    m_rdat = '0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, step the model over the coming edge, queue outputs.
    task automatic cyc(input bit ctl_n, input bit cpu_n, input bit ce_n, input bit s_hi,
                       input bit s_lo_n, input logic [AW-1:0] a, input bit wall_n,
                       input logic [LANES-1:0] lw, input logic [DW-1:0] din,
                       input bit oe_n, input bit slp, input string tag);
        bit ld, sel, wr;
        @(negedge clk);
        strobe_ctl_n = ctl_n; strobe_cpu_n = cpu_n; chip_en_n = ce_n;
        sel_hi = s_hi; sel_lo_n = s_lo_n; addr = a; wr_all_n = wall_n;
        lane_wr = lw; data_in = din; out_en_n = oe_n; sleep = slp;
        if (!slp) begin
            if (m_kind == 2) begin
                for (int i = 0; i < LANES; i++)
                    if (m_mask[i]) m_mem[m_addr][i*LANE_W +: LANE_W] = m_wdata[i*LANE_W +: LANE_W];
            end
            if (m_kind == 1) begin
                m_rdat = m_mem[m_addr];
                m_rsel = 1'b1;
            end else begin
                m_rsel = 1'b0;
            end
            ld  = !ctl_n || (!cpu_n && !ce_n);
            sel = !ce_n && s_hi && !s_lo_n;
            wr  = !wall_n || (lw != '0);
            if (ld) begin
                m_kind  = !sel ? 3 : (wr ? 2 : 1);
                m_addr  = a;
                m_mask  = wall_n ? lw : '1;
                m_wdata = din;
            end else if (m_kind == 2) begin
                m_kind = 1;
            end
        end
        q_drv.push_back(!oe_n && m_rsel && wall_n && (lw == '0));
        q_dat.push_back(m_rdat);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++)
            cyc(1, 1, 1, 0, 1, '0, 1, '0, '0, 0, 0, tag);
    endtask

    task automatic wr_op(input logic [AW-1:0] a, input bit wall_n, input logic [LANES-1:0] lw,
                         input logic [DW-1:0] din, input string tag);
        cyc(0, 1, 0, 1, 0, a, wall_n, lw, din, 0, 0, tag);
    endtask

    task automatic rd_op(input logic [AW-1:0] a, input string tag);
        cyc(0, 1, 0, 1, 0, a, 1, '0, '0, 0, 0, tag);
    endtask

    // Monitor: compare queued expectations shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_drv.size() > 0) begin
                bit            e_drv;
                logic [DW-1:0] e_dat;
                string         e_tag;
                e_drv = q_drv.pop_front();
                e_dat = q_dat.pop_front();
                e_tag = q_tag.pop_front();
                check({e_tag, " drive"}, {{(DW-1){1'b0}}, data_drive}, {{(DW-1){1'b0}}, e_drv});
                if (e_drv) check({e_tag, " data"}, data_out, e_dat);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 drive after reset", {{(DW-1){1'b0}}, data_drive}, '0);
        check("R1 data after reset", data_out, '0);
        rst_n = 1'b1;

        // R5, R6: full-word write, readback after write turns into read
        wr_op(8'd5, 0, 4'b0000, 36'h1_2345_6789, "R5");
        idle(3, "R6");
        // R5: lane write over a known word, via the processor strobe
        wr_op(8'd9, 0, 4'b0000, 36'h0_2468_ACE1, "R5");
        idle(1, "R6");
        cyc(1, 0, 0, 1, 0, 8'd9, 1, 4'b0101, 36'hF_FFFF_FFFF, 0, 0, "R5");
        idle(2, "R5");

        // R4: read latency via the processor strobe
        rd_op(8'd9, "R4");
        idle(1, "R4");
        cyc(1, 0, 0, 1, 0, 8'd5, 1, '0, '0, 0, 0, "R4");
        idle(2, "R4");

        // R2: processor strobe with chip enable high is ignored
        cyc(1, 0, 1, 1, 0, 8'd9, 1, '0, '0, 0, 0, "R2");
        idle(2, "R2");
        // R2: controller strobe loads with chip enable high -> deselect (R3)
        cyc(0, 1, 1, 1, 0, 8'd9, 1, '0, '0, 0, 0, "R2");
        idle(2, "R3");
        rd_op(8'd9, "R3");
        idle(2, "R3");
        cyc(0, 1, 0, 0, 0, 8'd9, 1, '0, '0, 0, 0, "R3");
        idle(2, "R3");
        rd_op(8'd5, "R3");
        idle(1, "R3");
        cyc(0, 1, 0, 1, 1, 8'd5, 0, '0, 36'h0, 0, 0, "R3");
        idle(2, "R3");

        // R7: held address is read again on idle edges
        rd_op(8'd5, "R7");
        idle(4, "R7");

        // R10: strobes and writes during sleep are lost; wake-up resumes
        cyc(0, 1, 0, 1, 0, 8'd5, 0, '0, 36'h0_0000_0000, 0, 1, "R10");
        cyc(0, 1, 0, 1, 0, 8'd9, 1, '0, '0, 0, 1, "R10");
        cyc(1, 1, 1, 0, 1, '0, 1, '0, '0, 0, 1, "R10");
        idle(3, "R10");
        rd_op(8'd9, "R10");
        idle(2, "R10");

        // R8: asynchronous output enable
        rd_op(8'd5, "R8");
        idle(2, "R8");
        @(posedge clk);
        #3;
        out_en_n = 1'b1;
        #0.5;
        check("R8 drive off without clock", {{(DW-1){1'b0}}, data_drive}, '0);
        out_en_n = 1'b0;
        #0.5;
        check("R8 drive back without clock", {{(DW-1){1'b0}}, data_drive}, {{(DW-1){1'b0}}, 1'b1});
        cyc(1, 1, 1, 0, 1, '0, 1, '0, '0, 1, 0, "R8");
        idle(1, "R8");

        // R9: write inputs without a strobe release the bus and write nothing
        cyc(1, 1, 1, 0, 1, 8'd5, 0, '0, 36'h0, 0, 0, "R9");
        cyc(1, 1, 1, 0, 1, 8'd5, 1, 4'b1000, 36'h0, 0, 0, "R9");
        idle(3, "R9");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule